// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a watchdog countdown timer with a small register port. An external single-cycle tick strobe paces the count, with a nominal tick period of 0.6 s. Software sets a 10-bit initial count, releases the timer by clearing a halt bit, and keeps the system alive by writing the reload register before the count runs out.

Escalation has two stages. The first expiry sets a timeout flag and, if enabled, sends a one-cycle event pulse to an interrupt or management agent. The counter then reloads and runs a second full period. If it expires again while the timeout flag is still set, the block records a second-timeout flag and a boot flag. It also requests a system reset, unless a no-reboot control bit blocks the request.

The register port is byte-addressed with 16-bit word registers at even addresses. Odd addresses and unused locations read as zero and ignore writes.

| Byte offset | Register | Fields |
|---|---|---|
| 0x0 | reload / current count | any write reloads; read gives count in [9:0] |
| 0x2 | status A | bit 3 timeout flag (write 1 to clear) |
| 0x4 | status B | bit 1 second-timeout flag, bit 2 boot flag (both write 1 to clear) |
| 0x6 | control | bit 11 halt, bit 0 no-reboot |
| 0x8 | initial count | [9:0] count, [15:10] stored only |
| 0xA | event enable | bit 13 |

Top module: `twostage_wdt`

## Requirements
- R1: After reset, control reads 0x0801 (halt and no-reboot set), the initial count register reads 0x0004, the count reads 4, both status registers and the event enable register read 0, and `evt_o` and `sysrst_o` are low.
- R2: While halt (control bit 11) is 0, each tick lowers the count by one. While halt is 1, ticks leave the count unchanged.
- R3: Any write to offset 0x0 loads the count from the initial count register, and this load takes priority over a tick in the same cycle. Reads of 0x0 return the count in bits [9:0] and zero above.
- R4: A write to offset 0x8 whose low 10 bits are below 4 is ignored entirely. Any other write stores all 16 bits, and all 16 bits read back.
- R5: A tick that arrives while the count is 0 is an expiry. An expiry reloads the initial count, so one period after a reload to N lasts N+1 ticks. The first expiry sets status A bit 3.
- R6: On an expiry with status A bit 3 clear, `evt_o` pulses high for exactly one cycle if event enable bit 13 is 1, and stays low otherwise.
- R7: Writing 1 to status A bit 3 clears it. Writing 0 leaves it set.
- R8: An expiry while status A bit 3 is set sets status B bit 1 and bit 2. Each of these bits clears on a write of 1 to it.
- R9: When no-reboot (control bit 0) is 0, such a second expiry drives `sysrst_o` high for exactly one cycle. After that, the count is frozen, reloads have no effect, and no further pulse occurs until hardware reset.
- R10: When no-reboot is 1, a second expiry sets the status B flags but does not assert `sysrst_o`.
- R11: Control bits 11 and 0 read back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-enable strobe, one cycle per tick |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| evt_o | output | 1 | First-expiry event pulse |
| sysrst_o | output | 1 | System reset request pulse |

## Verification
The assertions check on every cycle that the count holds while halted or frozen and drops by one on an active tick. They also check that a rejected initial-count write leaves the register unchanged, that the event pulse only occurs with the timeout flag set, and that the reset request lasts one cycle, comes with the second-timeout flag, and never follows an expiry blocked by no-reboot.

Some behaviour spans many cycles and only the bench scenarios can show it. This includes the exact length of a period, the difference between the first and second expiry, write-1-to-clear versus write-0, the reset state, and the permanent freeze after a reset request. The bench covers these with a behavioural model and with directed expectations.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned IDX_W  = ADDR_W - 1;

  // word index = byte address >> 1
  localparam logic [IDX_W-1:0] IDX_RELOAD = 3'd0;
  localparam logic [IDX_W-1:0] IDX_STSA   = 3'd1;
  localparam logic [IDX_W-1:0] IDX_STSB   = 3'd2;
  localparam logic [IDX_W-1:0] IDX_CTRL   = 3'd3;
  localparam logic [IDX_W-1:0] IDX_INIT   = 3'd4;
  localparam logic [IDX_W-1:0] IDX_EVEN   = 3'd5;

  // field positions software decodes
  localparam int unsigned BIT_TO       = 3;
  localparam int unsigned BIT_SEC      = 1;
  localparam int unsigned BIT_BOOT     = 2;
  localparam int unsigned BIT_HALT     = 11;
  localparam int unsigned BIT_NOREBOOT = 0;
  localparam int unsigned BIT_EVEN     = 13;
endpackage

// File: rtl/tsw_cfg.sv
module tsw_cfg
  import tsw_pkg::*;
#(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned MIN_INIT = 4,
  parameter int unsigned RST_INIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              to_sts_i,
  input  logic              sec_sts_i,
  input  logic              boot_sts_i,
  output logic              halt_o,
  output logic              noreboot_o,
  output logic              evten_o,
  output logic [CNT_W-1:0]  init_o,
  output logic              reload_o,
  output logic              clr_to_o,
  output logic              clr_sec_o,
  output logic              clr_boot_o
);
  logic [IDX_W-1:0]  idx;
  logic              word_ok;
  logic              wr_reload, wr_stsa, wr_stsb, wr_ctrl, wr_init, wr_even;
  logic              init_en, ctrl_en, even_en;
  logic [DATA_W-1:0] init_q, init_d;
  logic              halt_q, halt_d, nr_q, nr_d, even_q, even_d;

  assign idx     = addr_i[ADDR_W-1:1];
  assign word_ok = we_i && !addr_i[0];

  always_comb begin
    wr_reload = word_ok && (idx == IDX_RELOAD);
    wr_stsa   = word_ok && (idx == IDX_STSA);
    wr_stsb   = word_ok && (idx == IDX_STSB);
    wr_ctrl   = word_ok && (idx == IDX_CTRL);
    wr_init   = word_ok && (idx == IDX_INIT);
    wr_even   = word_ok && (idx == IDX_EVEN);
  end

  // next-state
  always_comb begin
    init_en = wr_init && (wdata_i[CNT_W-1:0] >= CNT_W'(MIN_INIT));
    ctrl_en = wr_ctrl;
    even_en = wr_even;
    init_d  = wdata_i;
    halt_d  = wdata_i[BIT_HALT];
    nr_d    = wdata_i[BIT_NOREBOOT];
    even_d  = wdata_i[BIT_EVEN];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= DATA_W'(RST_INIT);
      halt_q <= 1'b1;
      nr_q   <= 1'b1;
      even_q <= 1'b0;
    end else begin
      if (init_en) init_q <= init_d;
      if (ctrl_en) begin
        halt_q <= halt_d;
        nr_q   <= nr_d;
      end
      if (even_en) even_q <= even_d;
    end
  end

  assign halt_o     = halt_q;
  assign noreboot_o = nr_q;
  assign evten_o    = even_q;
  assign init_o     = init_q[CNT_W-1:0];
  assign reload_o   = wr_reload;
  assign clr_to_o   = wr_stsa && wdata_i[BIT_TO];
  assign clr_sec_o  = wr_stsb && wdata_i[BIT_SEC];
  assign clr_boot_o = wr_stsb && wdata_i[BIT_BOOT];

  always_comb begin
    rdata_o = '0;
    if (!addr_i[0]) begin
      case (idx)
        IDX_RELOAD: rdata_o[CNT_W-1:0] = cnt_i;
        IDX_STSA:   rdata_o[BIT_TO] = to_sts_i;
        IDX_STSB: begin
          rdata_o[BIT_SEC]  = sec_sts_i;
          rdata_o[BIT_BOOT] = boot_sts_i;
        end
        IDX_CTRL: begin
          rdata_o[BIT_HALT]     = halt_q;
          rdata_o[BIT_NOREBOOT] = nr_q;
        end
        IDX_INIT:   rdata_o = init_q;
        IDX_EVEN:   rdata_o[BIT_EVEN] = even_q;
        default:    rdata_o = '0;
      endcase
    end
  end

  // R4: a write with a low field under the floor leaves the register alone
  p_init_reject_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_init && (wdata_i[CNT_W-1:0] < CNT_W'(MIN_INIT))) |=> $stable(init_q));

  // R11: control write is reflected on the next cycle
  p_ctrl_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (halt_o == $past(wdata_i[BIT_HALT])));
endmodule

// File: rtl/tsw_counter.sv
module tsw_counter #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned RST_INIT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             freeze_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             active, at_zero, cnt_en;

  always_comb begin
    active   = tick_i && !halt_i && !freeze_i && !reload_i;
    at_zero  = (cnt_q == '0);
    expire_o = active && at_zero;
    cnt_en   = !freeze_i && (reload_i || active);
    if (reload_i || at_zero) cnt_d = init_i;
    else                     cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= CNT_W'(RST_INIT);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2: halted count does not move unless reloaded
  p_halt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !reload_i) |=> $stable(cnt_q));

  // R2: an active tick above zero lowers the count by one
  p_decrement_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !halt_i && !freeze_i && !reload_i && (cnt_q != '0))
      |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R9: frozen count never changes
  p_freeze_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(cnt_q));
endmodule

// File: rtl/tsw_stage.sv
module tsw_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_to_i,
  input  logic clr_sec_i,
  input  logic clr_boot_i,
  input  logic evten_i,
  input  logic noreboot_i,
  output logic to_sts_o,
  output logic sec_sts_o,
  output logic boot_sts_o,
  output logic evt_o,
  output logic sysrst_o,
  output logic freeze_o
);
  logic to_q, to_d, sec_q, sec_d, boot_q, boot_d;
  logic evt_q, evt_d, rst_q, rst_d, frz_q, frz_d;
  logic first_exp, second_exp;

  always_comb begin
    first_exp  = expire_i && !to_q;
    second_exp = expire_i && to_q;
    to_d   = (to_q && !clr_to_i) || first_exp;
    sec_d  = (sec_q && !clr_sec_i) || second_exp;
    boot_d = (boot_q && !clr_boot_i) || second_exp;
    evt_d  = first_exp && evten_i;
    rst_d  = second_exp && !noreboot_i;
    frz_d  = frz_q || rst_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_q   <= 1'b0;
      sec_q  <= 1'b0;
      boot_q <= 1'b0;
      evt_q  <= 1'b0;
      rst_q  <= 1'b0;
      frz_q  <= 1'b0;
    end else begin
      to_q   <= to_d;
      sec_q  <= sec_d;
      boot_q <= boot_d;
      evt_q  <= evt_d;
      rst_q  <= rst_d;
      frz_q  <= frz_d;
    end
  end

  assign to_sts_o   = to_q;
  assign sec_sts_o  = sec_q;
  assign boot_sts_o = boot_q;
  assign evt_o      = evt_q;
  assign sysrst_o   = rst_q;
  assign freeze_o   = frz_q;

  // R9: reset request lasts a single cycle
  p_rst_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysrst_o |=> !sysrst_o);

  // R8: a reset request is always accompanied by the second-timeout flag
  p_rst_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysrst_o |-> sec_sts_o);

  // R6: event pulse only when the first-stage flag is up
  p_evt_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> to_sts_o);

  // R10: a blocked second expiry produces no request
  p_noreboot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && to_q && noreboot_i) |=> !sysrst_o);
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import tsw_pkg::*;
#(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned MIN_INIT = 4,
  parameter int unsigned RST_INIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              evt_o,
  output logic              sysrst_o
);
  logic [CNT_W-1:0] cnt, init;
  logic halt, noreboot, evten, reload, clr_to, clr_sec, clr_boot;
  logic to_sts, sec_sts, boot_sts, expire, freeze;

  tsw_cfg #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT), .RST_INIT(RST_INIT)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cnt_i(cnt),
    .to_sts_i(to_sts), .sec_sts_i(sec_sts), .boot_sts_i(boot_sts),
    .halt_o(halt), .noreboot_o(noreboot), .evten_o(evten), .init_o(init),
    .reload_o(reload), .clr_to_o(clr_to), .clr_sec_o(clr_sec),
    .clr_boot_o(clr_boot)
  );

  tsw_counter #(.CNT_W(CNT_W), .RST_INIT(RST_INIT)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .halt_i(halt),
    .freeze_i(freeze), .reload_i(reload), .init_i(init),
    .cnt_o(cnt), .expire_o(expire)
  );

  tsw_stage u_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(expire),
    .clr_to_i(clr_to), .clr_sec_i(clr_sec), .clr_boot_i(clr_boot),
    .evten_i(evten), .noreboot_i(noreboot),
    .to_sts_o(to_sts), .sec_sts_o(sec_sts), .boot_sts_o(boot_sts),
    .evt_o(evt_o), .sysrst_o(sysrst_o), .freeze_o(freeze)
  );
endmodule

// File: tb/twostage_wdt_tb.sv
module twostage_wdt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        evt, sysrst;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rst_seen = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  twostage_wdt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_o(evt), .sysrst_o(sysrst)
  );

  // behavioural reference
  int m_cnt, m_init, m_halt, m_nr, m_even, m_to, m_sec, m_boot, m_evt, m_rst, m_dead;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 4; m_init = 4; m_halt = 1; m_nr = 1; m_even = 0;
      m_to = 0; m_sec = 0; m_boot = 0; m_evt = 0; m_rst = 0; m_dead = 0;
    end else begin
      int widx, rl, act, ex, first, second, ncnt;
      widx = (we && !addr[0]) ? int'(addr[3:1]) : -1;
      rl   = (widx == 0);
      act  = tick && !m_halt && !m_dead && !rl;
      ex   = act && (m_cnt == 0);
      ncnt = m_cnt;
      if (!m_dead) begin
        if (rl || ex) ncnt = m_init & 16'h3ff;
        else if (act) ncnt = m_cnt - 1;
      end
      first  = ex && !m_to;
      second = ex && m_to;
      if (widx == 1 && wdata[3]) m_to = 0;
      if (first) m_to = 1;
      if (widx == 2 && wdata[1]) m_sec = 0;
      if (widx == 2 && wdata[2]) m_boot = 0;
      if (second) begin m_sec = 1; m_boot = 1; end
      m_evt = first && m_even;
      m_rst = second && !m_nr;
      if (m_rst) m_dead = 1;
      if (widx == 4 && (wdata & 16'h3ff) >= 4) m_init = wdata;
      if (widx == 3) begin m_halt = wdata[11]; m_nr = wdata[0]; end
      if (widx == 5) m_even = wdata[13];
      m_cnt = ncnt;
    end
  end

  function automatic int model_read(input logic [3:0] a);
    if (a[0]) return 0;
    case (a[3:1])
      3'd0: return m_cnt;
      3'd1: return m_to << 3;
      3'd2: return (m_sec << 1) | (m_boot << 2);
      3'd3: return (m_halt << 11) | m_nr;
      3'd4: return m_init;
      3'd5: return m_even << 13;
      default: return 0;
    endcase
  endfunction

  // per-cycle comparison against the model (R2, R5, R6, R9)
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      checks++;
      if (evt !== m_evt[0] || sysrst !== m_rst[0] || int'(rdata) != model_read(addr)) begin
        errors++;
        $display("FAIL R2 model cycle %0d: evt=%0b/%0d rst=%0b/%0d rdata=%h exp %h",
                 cyc, evt, m_evt, sysrst, m_rst, rdata, model_read(addr));
      end
      if (sysrst) rst_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, input int exp, input string tag);
    @(negedge clk);
    we = 1'b0; addr = a;
    #1;
    chk(int'(rdata), exp, tag);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(evt, 0, "R1 evt after reset");
    chk(sysrst, 0, "R1 sysrst after reset");
    rd(4'h6, 16'h0801, "R1 control");
    rd(4'h8, 16'h0004, "R1 initial count");
    rd(4'h0, 4, "R1 count");
    rd(4'h2, 0, "R1 status A");
    rd(4'h4, 0, "R1 status B");
    rd(4'hA, 0, "R1 event enable");

    wr(4'h8, 16'h0003);
    rd(4'h8, 16'h0004, "R4 value under floor ignored");
    wr(4'h8, 16'hFC0A);
    rd(4'h8, 16'hFC0A, "R4 full word stored");
    rd(4'h0, 4, "R3 count unchanged before reload");
    wr(4'h0, 16'h0000);
    rd(4'h0, 10, "R3 reload loads initial count");

    ticks(3);
    rd(4'h0, 10, "R2 halted count holds");
    wr(4'h6, 16'h0001);
    rd(4'h6, 16'h0001, "R11 control readback");
    ticks(3);
    rd(4'h0, 7, "R2 three ticks decrement");
    ticks(7);
    rd(4'h0, 0, "R5 count at zero");
    rd(4'h2, 0, "R5 no flag before expiry");
    ticks(1);
    chk(evt, 0, "R6 no event when disabled");
    rd(4'h0, 10, "R5 expiry reloads");
    rd(4'h2, 16'h0008, "R5 timeout flag set");

    wr(4'h2, 16'h0000);
    rd(4'h2, 16'h0008, "R7 write zero keeps flag");
    wr(4'h2, 16'h0008);
    rd(4'h2, 0, "R7 write one clears flag");

    wr(4'hA, 16'h2000);
    wr(4'h0, 16'h0000);
    ticks(11);
    chk(evt, 1, "R6 event pulse");
    @(negedge clk); #1;
    chk(evt, 0, "R6 event single cycle");
    rd(4'h2, 16'h0008, "R5 flag set again");

    ticks(11);
    chk(sysrst, 0, "R10 blocked request");
    rd(4'h4, 16'h0006, "R8 second stage flags");
    chk(rst_seen, 0, "R10 no request seen");
    wr(4'h4, 16'h0002);
    rd(4'h4, 16'h0004, "R8 clear second-timeout only");
    wr(4'h4, 16'h0004);
    rd(4'h4, 0, "R8 clear boot flag");

    wr(4'h6, 16'h0000);
    rd(4'h6, 0, "R11 control cleared");
    wr(4'h0, 16'h0000);
    ticks(10);
    chk(rst_seen, 0, "R9 no request before expiry");
    ticks(1);
    chk(sysrst, 1, "R9 reset request");
    @(negedge clk); #1;
    chk(sysrst, 0, "R9 request single cycle");
    rd(4'h4, 16'h0006, "R8 flags on requested reset");
    wr(4'h0, 16'h0000);
    ticks(30);
    rd(4'h0, 10, "R9 count frozen");
    chk(rst_seen, 1, "R9 exactly one request");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule